// File: doc/BRIEF.md
# Rotational Quarter-Rate Frequency Detector

This block is the frequency-acquisition helper of a quarter-rate clock-recovery loop. The recovered clock exists as several phases spaced evenly over one clock period. Each time the incoming data makes a transition, all of those phases are captured at that instant, and the captured levels arrive here together with a one-cycle strobe. The block turns the captured levels into one of four phase quadrants and keeps that quadrant until the next data transition.

When the recovered clock runs at the data rate, the quadrant seen at successive data transitions does not move. A frequency error makes it rotate, and the direction of rotation tells which way the oscillator must be pulled. A step of one quadrant in the forward direction means the data is slower than the clock, and the block emits a one-cycle down pulse. A step of one quadrant backward means the data is faster, and the block emits a one-cycle up pulse. A step of two quadrants gives no usable direction and is ignored.

An enable input lets the loop switch the detector off once frequency is acquired, so that the phase loop alone steers the oscillator. While it is off, the block keeps following the quadrant. Turning it back on therefore cannot produce a stale pulse. Two decoders are available through a parameter: a full edge search over every captured phase, and a cheap decoder that uses two taps.

Top module: `quad_rot_fd`

## Requirements
- R1: After reset, `up` and `dn` are 0 and `quad` is 2'b00, the code of quadrant 0.
- R2: Quadrant q (0..3) is reported on `quad` as a Gray code: 0 is 00, 1 is 01, 2 is 11 and 3 is 10. In search mode (DECODE_MODE=0), the decoder looks for the lowest phase index k with `ph_smp[k]`=1 and `ph_smp[(k+1) mod NPHASE]`=0. The octant is k, and the quadrant is k divided by NPHASE/4, rounded down. In tap mode (DECODE_MODE=1), `quad` = {~`ph_smp[0]`, `ph_smp[NPHASE/4]`}.
- R3: `quad` changes only in the cycle that follows a cycle with `edge_vld`=1. In every other cycle it holds.
- R4: If the new quadrant equals the held quadrant plus 1 (mod 4), `dn` is 1 for exactly the one cycle after the strobe, and `up` stays 0.
- R5: If the new quadrant equals the held quadrant minus 1 (mod 4), `up` is 1 for exactly the one cycle after the strobe, and `dn` stays 0.
- R6: If the quadrant stays the same or moves by two, neither output pulses.
- R7: The first valid strobe after reset only loads the quadrant and produces no pulse, whatever quadrant it carries.
- R8: If `enable` is 0 when a strobe arrives, neither output pulses, but the held quadrant is still updated. A later strobe with `enable`=1 is compared against that updated quadrant.
- R9: In search mode, a sample set with no 1-to-0 step (all ones or all zeros) is ignored. `quad` does not change, no pulse is produced, and the next strobe is compared against the quadrant held before.
- R10: `up` and `dn` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| edge_vld | input | 1 | One-cycle strobe: a data transition captured `ph_smp` |
| enable | input | 1 | 1 lets pulses through; 0 suppresses them but keeps the quadrant tracked |
| ph_smp | input | NPHASE | Clock phase levels captured at the data transition; bit k is the phase delayed by k/NPHASE of a period |
| up | output | 1 | One-cycle pulse: data faster than clock, raise frequency |
| dn | output | 1 | One-cycle pulse: data slower than clock, lower frequency |
| quad | output | 2 | Held quadrant, Gray coded |

## Verification
The bench builds the block with eight phases and the edge-search decoder. With this small configuration, every ordered pair of the eight clean octant patterns can be swept, once with the detector enabled and once with it disabled. That covers every rotation step, both directions, the two-quadrant jump and the no-change case, and it also covers every pair of octants that fall inside the same quadrant. The bench also drives the all-ones and all-zeros patterns, a pattern with two 1-to-0 steps where the lowest one must decide, the first strobe after reset, and a disable followed by re-enable.

// File: rtl/rfd_pkg.sv
package rfd_pkg;

   typedef logic [1:0] quad_t;

   typedef enum logic [1:0] {
      ROT_HOLD = 2'd0,
      ROT_FWD  = 2'd1,
      ROT_JUMP = 2'd2,
      ROT_BACK = 2'd3
   } rot_e;

   function automatic quad_t bin2gray(input logic [1:0] b);
      return {b[1], b[1] ^ b[0]};
   endfunction

   function automatic logic [1:0] gray2bin(input quad_t g);
      return {g[1], g[1] ^ g[0]};
   endfunction

   function automatic rot_e classify(input quad_t prev_g, input quad_t next_g);
      logic [1:0] d;
      d = 2'(gray2bin(next_g) - gray2bin(prev_g));
      return rot_e'(d);
   endfunction

endpackage

// File: rtl/rfd_phase_decode.sv
module rfd_phase_decode
   import rfd_pkg::*;
#(
   parameter int NPHASE      = 8,
   parameter int DECODE_MODE = 0
) (
   input  logic [NPHASE-1:0] ph_smp,
   output quad_t             quad_g,
   output logic              pat_ok
);
   localparam int QSPAN = NPHASE / 4;
   localparam int OW    = $clog2(NPHASE);

   generate
      if (DECODE_MODE == 0) begin : g_search
         logic [OW-1:0] oct;
         logic          hit;
         always_comb begin
            oct = '0;
            hit = 1'b0;
            for (int k = NPHASE - 1; k >= 0; k--) begin
               if (ph_smp[k] && !ph_smp[(k + 1) % NPHASE]) begin
                  oct = OW'(k);
                  hit = 1'b1;
               end
            end
         end
         assign quad_g = bin2gray(2'(oct / OW'(QSPAN)));
         assign pat_ok = hit;
      end else begin : g_tap
         assign quad_g = {~ph_smp[0], ph_smp[QSPAN]};
         assign pat_ok = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/rfd_quad_hold.sv
module rfd_quad_hold
   import rfd_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load,
   input  logic  strobe,
   input  quad_t quad_in,
   output quad_t quad_q,
   output logic  seen_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         quad_q <= '0;
         seen_q <= 1'b0;
      end else if (load) begin
         quad_q <= quad_in;
         seen_q <= 1'b1;
      end
   end

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(strobe) |-> $stable(quad_q));

endmodule

// File: rtl/rfd_rot_compare.sv
module rfd_rot_compare
   import rfd_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load,
   input  logic  seen,
   input  logic  enable,
   input  quad_t prev_g,
   input  quad_t next_g,
   output logic  up,
   output logic  dn
);
   rot_e rot;
   logic fire;

   assign rot  = classify(prev_g, next_g);
   assign fire = load && seen && enable;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         up <= 1'b0;
         dn <= 1'b0;
      end else begin
         up <= fire && (rot == ROT_BACK);
         dn <= fire && (rot == ROT_FWD);
      end
   end

   p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(up && dn));

   p_dn_fwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dn |-> (2'(gray2bin(prev_g) - gray2bin($past(prev_g))) == 2'd1));

   p_up_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
      up |-> (2'(gray2bin($past(prev_g)) - gray2bin(prev_g)) == 2'd1));

endmodule

// File: rtl/quad_rot_fd.sv
module quad_rot_fd
   import rfd_pkg::*;
#(
   parameter int NPHASE      = 8,
   parameter int DECODE_MODE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              edge_vld,
   input  logic              enable,
   input  logic [NPHASE-1:0] ph_smp,
   output logic              up,
   output logic              dn,
   output logic [1:0]        quad
);
   initial begin
      assert (NPHASE >= 4 && (NPHASE % 4) == 0)
         else $error("NPHASE must be a multiple of 4");
      assert (DECODE_MODE == 0 || DECODE_MODE == 1)
         else $error("DECODE_MODE must be 0 or 1");
   end

   quad_t dec_g;
   quad_t held_g;
   logic  pat_ok;
   logic  seen;
   logic  load;

   rfd_phase_decode #(.NPHASE(NPHASE), .DECODE_MODE(DECODE_MODE)) u_dec (
      .ph_smp (ph_smp),
      .quad_g (dec_g),
      .pat_ok (pat_ok)
   );

   assign load = edge_vld && pat_ok;

   rfd_quad_hold u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .strobe  (edge_vld),
      .quad_in (dec_g),
      .quad_q  (held_g),
      .seen_q  (seen)
   );

   rfd_rot_compare u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .seen   (seen),
      .enable (enable),
      .prev_g (held_g),
      .next_g (dec_g),
      .up     (up),
      .dn     (dn)
   );

   assign quad = held_g;

   p_after_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (up || dn) |-> $past(edge_vld));

   p_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (up || dn) |-> $past(seen));

   p_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (up || dn) |-> $past(enable));

endmodule

// File: tb/test_quad_rot_fd.sv
module test_quad_rot_fd;
   localparam int CLK_PERIOD = 10;
   localparam int NP         = 8;
   localparam int WDOG       = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          edge_vld = 1'b0;
   logic          enable = 1'b1;
   logic [NP-1:0] ph_smp = '0;
   logic          up, dn;
   logic [1:0]    quad;

   int errors = 0;
   int checks = 0;
   int exp_q = 0;
   bit exp_seen = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   quad_rot_fd #(.NPHASE(NP), .DECODE_MODE(0)) i_quad_rot_fd (
      .clk(clk), .rst_n(rst_n), .edge_vld(edge_vld), .enable(enable),
      .ph_smp(ph_smp), .up(up), .dn(dn), .quad(quad)
   );

   function automatic logic [NP-1:0] oct_pat(input int o);
      logic [NP-1:0] p;
      for (int k = 0; k < NP; k++) p[k] = (((o - k) % NP + NP) % NP) < NP / 2;
      return p;
   endfunction

   function automatic logic [1:0] gray(input int q);
      return 2'(q ^ (q >> 1));
   endfunction

   task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [NP-1:0] p, input bit en, input bit ok,
                        input int qexp, input string tag);
      int  d;
      bit  e_up, e_dn;
      @(negedge clk);
      ph_smp = p; edge_vld = 1'b1; enable = en;
      @(negedge clk);
      edge_vld = 1'b0;
      e_up = 1'b0; e_dn = 1'b0;
      if (ok) begin
         d = (qexp - exp_q) & 3;
         e_dn = en && exp_seen && d == 1;
         e_up = en && exp_seen && d == 3;
         exp_q = qexp;
         exp_seen = 1'b1;
      end
      chk({tag, " quad"}, quad, gray(exp_q));
      chk({tag, " up"}, {1'b0, up}, {1'b0, e_up});
      chk({tag, " dn"}, {1'b0, dn}, {1'b0, e_dn});
      @(negedge clk);
      chk("R3 idle quad", quad, gray(exp_q));
      chk("R4 R5 pulse width", {up, dn}, 2'b00);
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset quad", quad, 2'b00);
      chk("R1 reset pulses", {up, dn}, 2'b00);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", {up, dn, quad}, 4'b0000);

      // first strobe: would be a forward step from quadrant 0
      apply(oct_pat(2), 1'b1, 1'b1, 1, "R7 first edge");

      // exhaustive octant pairs, enabled and disabled
      for (int en = 1; en >= 0; en--)
         for (int o1 = 0; o1 < NP; o1++)
            for (int o2 = 0; o2 < NP; o2++) begin
               apply(oct_pat(o1), 1'b1, 1'b1, o1 / 2, "R2 R4 R5 R6 ref");
               apply(oct_pat(o2), en[0], 1'b1, o2 / 2,
                     en ? "R2 R4 R5 R6 step" : "R8 disabled step");
            end

      // re-enable after a disabled move: no stale pulse
      apply(oct_pat(0), 1'b1, 1'b1, 0, "R8 ref");
      apply(oct_pat(2), 1'b0, 1'b1, 1, "R8 off");
      apply(oct_pat(3), 1'b1, 1'b1, 1, "R8 reenable");

      // invalid patterns ignored
      apply(oct_pat(4), 1'b1, 1'b1, 2, "R9 ref");
      apply('1, 1'b1, 1'b0, 2, "R9 all ones");
      apply('0, 1'b1, 1'b0, 2, "R9 all zeros");
      apply(oct_pat(6), 1'b1, 1'b1, 3, "R9 after invalid");

      // two steps at k=1 and k=5: lowest decides -> quadrant 0, a forward step from 3
      apply(8'b0010_0011, 1'b1, 1'b1, 0, "R2 bubble");

      // back-to-back strobes: never both outputs
      for (int o = 0; o < NP; o++) begin
         @(negedge clk);
         ph_smp = oct_pat((NP - o * 2) % NP); edge_vld = 1'b1; enable = 1'b1;
         @(negedge clk);
         checks++;
         if (up && dn) begin
            errors++;
            $display("FAIL R10 actual=11 expected=not both");
         end
      end
      edge_vld = 1'b0;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule